// File: doc/BRIEF.md
# Dual-Mode PWM Timer Counter

This block is an 8-bit timer/counter that produces two pulse-width-modulated outputs. A free-running prescaler turns the system clock into a count enable at one of seven division ratios, or stops the counter. A two-bit wave-mode select picks one of three modes. In clear-on-compare mode the counter restarts after compare value A. In single-slope (fast) PWM mode the counter ramps up to TOP and wraps. In dual-slope (phase-correct) PWM mode it ramps up to TOP and back down to zero. In both PWM modes, TOP is either the full count of 0xFF or compare value A.

Each of the two output channels has its own compare value and a two-bit output action. The action is one of: held off, toggle on match, non-inverting, or inverting. Compare values are written through a single shared data bus with one write strobe per channel. In clear-on-compare mode a write takes effect at once. In the PWM modes it goes to a holding register and reaches the active compare only at the point where the counter leaves TOP. This keeps each PWM period glitch free.

An overflow flag marks each return to zero. A host clears it with a one-cycle pulse, and it raises an interrupt line when that line is enabled.

Top module: `pwm_timer`

## Requirements
- R1: After reset, `count` is 0 and `out_a`, `out_b`, `ovf_flag` and `irq` are all 0.
- R2: `clk_sel` codes 1 to 7 advance the counter once every 1, 8, 32, 64, 128, 256 and 1024 clocks respectively. Code 0 holds `count` unchanged.
- R3: In single-slope mode (`wave_mode` = 1) the counter steps 0, 1, …, TOP, 0, … . TOP is 0xFF when `top_sel` = 0 and is the active compare A value when `top_sel` = 1.
- R4: In dual-slope mode (`wave_mode` = 2) the counter steps up to TOP and then down to 0. TOP and 0 each appear for exactly one step; for example, with TOP = 5 the sequence is 1,2,3,4,5,4,3,2,1,0,1. TOP is chosen as in R3.
- R5: `ovf_flag` sets on the step that brings the counter to 0. This is the wrap in modes 0, 1 and 3, and the arrival from 1 in mode 2. A one-cycle `ovf_clr` pulse clears the flag. `irq` is high exactly when `ovf_flag` and `ovf_ie` are both high.
- R6: In single-slope mode with output action 2, a channel output is high while `count` ≤ its compare value; action 3 inverts this. A compare value of 0 gives a one-step pulse at count 0 in each period. A compare value of 0xFF with TOP 0xFF gives a constant level: high for action 2, low for action 3.
- R7: In dual-slope mode with output action 2, a channel output clears on a compare match reached while counting up and sets on a match reached while counting down. Action 3 does the reverse.
- R8: Output action 1 toggles the output on every step that lands on the compare value. With single-slope mode, `top_sel` = 1 and compare A = 0, `out_a` toggles on every step.
- R9: In modes 0 and 3 (clear-on-compare, TOP always compare A) a compare write takes effect on the next clock. In modes 1 and 2 it takes effect only on the step that moves the counter away from TOP.
- R10: Output action 0 holds the channel output low regardless of compare matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Prescaler select: 0 stop, 1..7 divide by 1/8/32/64/128/256/1024 |
| wave_mode | input | 2 | 0/3 clear-on-compare, 1 single-slope PWM, 2 dual-slope PWM |
| top_sel | input | 1 | PWM TOP: 0 = 0xFF, 1 = compare A |
| cmp_a_wr | input | 1 | Write strobe for compare A |
| cmp_b_wr | input | 1 | Write strobe for compare B |
| cmp_wdata | input | 8 | Compare write data |
| com_a | input | 2 | Output action for channel A |
| com_b | input | 2 | Output action for channel B |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| count | output | 8 | Current counter value |
| out_a | output | 1 | Channel A waveform |
| out_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest situation to reach from the ports is the dual-slope update window. The new compare value must be written while the counter is still rising and must stay invisible until the counter turns at TOP. The stimulus waits for a chosen count on the rising slope, then writes a smaller compare value. It then samples the output at two counts on the falling slope that tell the old value from the new one. The single-slope buffering gets the same treatment: the same count is sampled across two periods, one before the wrap and one after it.

// File: rtl/pwm_tmr_pkg.sv
// Shared types and helpers for the PWM timer.
// Assumes an 8-bit default counter and a 10-bit prescaler chain.
package pwm_tmr_pkg;

    localparam int PRE_W = 10;

    typedef enum logic [1:0] {
        WM_CTC     = 2'd0,
        WM_FAST    = 2'd1,
        WM_PHASE   = 2'd2,
        WM_CTC_ALT = 2'd3
    } wave_mode_e;

    // Map a prescaler select code to the mask of low prescaler bits.
    function automatic logic [PRE_W-1:0] pre_mask(input logic [2:0] sel);
        case (sel)
            3'd2:    pre_mask = PRE_W'(7);
            3'd3:    pre_mask = PRE_W'(31);
            3'd4:    pre_mask = PRE_W'(63);
            3'd5:    pre_mask = PRE_W'(127);
            3'd6:    pre_mask = PRE_W'(255);
            3'd7:    pre_mask = PRE_W'(1023);
            default: pre_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Prescaler: produces a one-cycle count enable every 1..1024 clocks.
// Assumes the division ratios are powers of two that divide 2**PRE_W.
// Select 0 holds the chain at zero and gives no enable.
module pwm_prescaler
    import pwm_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] mask;

    assign mask = pre_mask(clk_sel);
    assign tick = (clk_sel != 3'd0) && ((pcnt_q & mask) == mask);

    // Free-running divider chain, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || clk_sel == 3'd0) pcnt_q <= '0;
        else                           pcnt_q <= pcnt_q + 1'b1;
    end

endmodule

// File: rtl/pwm_counter.sv
// Counter core: single-slope or dual-slope stepping on each enable.
// Produces the next count and direction so that the output logic can
// register in the same edge. Flags the step to BOTTOM (overflow) and the
// step that leaves TOP (compare buffer load point).
module pwm_counter
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wave_mode_e       mode,
    input  logic             top_sel,
    input  logic [CNT_W-1:0] cmp_a_act,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             up_nxt,
    output logic             ovf_evt,
    output logic             load_evt
);

    logic             up_q;
    logic [CNT_W-1:0] top;

    // Select TOP: full scale in PWM modes unless compare A is chosen.
    always_comb begin
        if ((mode == WM_FAST || mode == WM_PHASE) && !top_sel) top = '1;
        else                                                 top = cmp_a_act;
    end

    // Next-state stepping for both slope styles.
    always_comb begin
        cnt_nxt  = cnt_q;
        up_nxt   = (mode == WM_PHASE) ? up_q : 1'b1;
        ovf_evt  = 1'b0;
        load_evt = 1'b0;
        if (tick) begin
            if (mode == WM_PHASE) begin
                if (up_q) begin
                    if (cnt_q >= top) begin
                        cnt_nxt  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                        up_nxt   = 1'b0;
                        load_evt = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q + 1'b1;
                    end
                end else if (cnt_q == '0) begin
                    cnt_nxt = cnt_q + 1'b1;
                    up_nxt  = 1'b1;
                end else begin
                    cnt_nxt = cnt_q - 1'b1;
                    ovf_evt = (cnt_q == CNT_W'(1));
                end
            end else if (cnt_q >= top) begin
                cnt_nxt  = '0;
                ovf_evt  = 1'b1;
                load_evt = (mode == WM_FAST);
            end else begin
                cnt_nxt = cnt_q + 1'b1;
            end
        end
    end

    // Count and direction state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            up_q  <= up_nxt;
        end
    end

endmodule

// File: rtl/pwm_cmp_buf.sv
// Compare register pair: a holding register that takes every write and an
// active register. The active register updates at once in clear-on-compare
// mode and on the load event in the PWM modes.
module pwm_cmp_buf #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             imm,
    input  logic             load,
    output logic [CNT_W-1:0] act_q,
    output logic [CNT_W-1:0] act_nxt
);

    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] hold_nxt;

    assign hold_nxt = wr ? wdata : hold_q;

    // Choose the value the active compare will hold after this edge.
    always_comb begin
        if (imm && wr) act_nxt = wdata;
        else if (load) act_nxt = hold_nxt;
        else           act_nxt = act_q;
    end

    // Holding and active compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            hold_q <= hold_nxt;
            act_q  <= act_nxt;
        end
    end

endmodule

// File: rtl/pwm_out_unit.sv
// One waveform output. Decides the next level from the next count, the
// next compare value and the direction of the step, so that the output
// changes on the same edge as the count. Action 0 forces the output low.
module pwm_out_unit
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wave_mode_e       mode,
    input  logic [1:0]       com,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             up_nxt,
    input  logic [CNT_W-1:0] cmp_nxt,
    output logic             out_q
);

    logic out_nxt;
    logic match;
    logic inv;

    assign match = (cnt_nxt == cmp_nxt);
    assign inv   = (com == 2'd3);

    // Output action per mode.
    always_comb begin
        out_nxt = out_q;
        if (com == 2'd0) begin
            out_nxt = 1'b0;
        end else if (tick) begin
            if (com == 2'd1) begin
                if (match) out_nxt = ~out_q;
            end else begin
                case (mode)
                    WM_FAST:  out_nxt = (cnt_nxt <= cmp_nxt) ^ inv;
                    WM_PHASE: if (match) out_nxt = (~up_nxt) ^ inv;
                    default:  if (match) out_nxt = inv;
                endcase
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_nxt;
    end

endmodule

// File: rtl/pwm_timer.sv
// PWM timer top: prescaler, counter core, two compare channels and the
// overflow flag. Assumes inputs are synchronous to clk.
module pwm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [1:0]       wave_mode,
    input  logic             top_sel,
    input  logic             cmp_a_wr,
    input  logic             cmp_b_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       com_a,
    input  logic [1:0]       com_b,
    input  logic             ovf_ie,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             out_a,
    output logic             out_b,
    output logic             ovf_flag,
    output logic             irq
);

    localparam int N_CH = 2;

    wave_mode_e       mode;
    logic             tick;
    logic [CNT_W-1:0] cnt_nxt;
    logic             up_nxt;
    logic             ovf_evt;
    logic             load_evt;
    logic             imm;
    logic [N_CH-1:0]  ch_wr;
    logic [1:0]       ch_com [N_CH];
    logic [CNT_W-1:0] cmp_act [N_CH];
    logic [CNT_W-1:0] cmp_nxt [N_CH];
    logic [N_CH-1:0]  ch_out;
    logic             flag_q;

    assign mode      = wave_mode_e'(wave_mode);
    assign imm       = (mode == WM_CTC) || (mode == WM_CTC_ALT);
    assign ch_wr     = {cmp_b_wr, cmp_a_wr};
    assign ch_com[0] = com_a;
    assign ch_com[1] = com_b;

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .top_sel   (top_sel),
        .cmp_a_act (cmp_act[0]),
        .cnt_q     (count),
        .cnt_nxt   (cnt_nxt),
        .up_nxt    (up_nxt),
        .ovf_evt   (ovf_evt),
        .load_evt  (load_evt)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        pwm_cmp_buf #(.CNT_W(CNT_W)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (ch_wr[ch]),
            .wdata   (cmp_wdata),
            .imm     (imm),
            .load    (load_evt),
            .act_q   (cmp_act[ch]),
            .act_nxt (cmp_nxt[ch])
        );

        pwm_out_unit #(.CNT_W(CNT_W)) u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .mode    (mode),
            .com     (ch_com[ch]),
            .cnt_nxt (cnt_nxt),
            .up_nxt  (up_nxt),
            .cmp_nxt (cmp_nxt[ch]),
            .out_q   (ch_out[ch])
        );
    end

    // Overflow flag: a set on reaching BOTTOM wins over a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (tick && ovf_evt) flag_q <= 1'b1;
        else if (ovf_clr)        flag_q <= 1'b0;
    end

    assign out_a    = ch_out[0];
    assign out_b    = ch_out[1];
    assign ovf_flag = flag_q;
    assign irq      = flag_q & ovf_ie;

endmodule

// File: rtl/pwm_timer_chk.sv
// Checker for pwm_timer: port-level temporal properties.
module pwm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic [1:0]       wave_mode,
    input logic [1:0]       com_a,
    input logic [CNT_W-1:0] count,
    input logic             out_a,
    input logic             ovf_flag
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0 && !out_a && !ovf_flag));

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0) |=> $stable(count));

    // R4
    dual_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 2'd2 && $past(wave_mode) == 2'd2 && $past(rst_n))
        |-> (count == $past(count) || count == $past(count) + 1'b1
             || count + 1'b1 == $past(count)));

    // R5
    ovf_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0));

    // R10
    com_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(com_a) == 2'd0) |-> !out_a);

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .wave_mode (wave_mode),
    .com_a     (com_a),
    .count     (count),
    .out_a     (out_a),
    .ovf_flag  (ovf_flag)
);

// File: tb/pwm_timer_tb.sv
// Directed bench for pwm_timer: one task per scenario.
module pwm_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = '0;
    logic [1:0] wave_mode = '0;
    logic       top_sel = 1'b0;
    logic       cmp_a_wr = 1'b0;
    logic       cmp_b_wr = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic [1:0] com_a = '0;
    logic [1:0] com_b = '0;
    logic       ovf_ie = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] count;
    logic       out_a;
    logic       out_b;
    logic       ovf_flag;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
        .top_sel(top_sel), .cmp_a_wr(cmp_a_wr), .cmp_b_wr(cmp_b_wr),
        .cmp_wdata(cmp_wdata), .com_a(com_a), .com_b(com_b),
        .ovf_ie(ovf_ie), .ovf_clr(ovf_clr), .count(count), .out_a(out_a),
        .out_b(out_b), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clk_sel = '0; wave_mode = '0; top_sel = 1'b0;
        cmp_a_wr = 1'b0; cmp_b_wr = 1'b0; cmp_wdata = '0;
        com_a = '0; com_b = '0; ovf_ie = 1'b0; ovf_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cmp(input bit chan_b, input logic [7:0] val);
        @(negedge clk);
        cmp_wdata = val;
        if (chan_b) cmp_b_wr = 1'b1; else cmp_a_wr = 1'b1;
        @(negedge clk);
        cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
    endtask

    // Reset, load compares while stopped in immediate mode, then start.
    task automatic setup(input logic [1:0] wm, input logic ts, input logic [7:0] a,
                         input logic [7:0] b, input logic [1:0] ca, input logic [1:0] cb);
        do_reset();
        write_cmp(1'b0, a);
        write_cmp(1'b1, b);
        @(negedge clk);
        wave_mode = wm; top_sel = ts; com_a = ca; com_b = cb; clk_sel = 3'd1;
    endtask

    task automatic wait_count(input logic [7:0] v);
        do @(negedge clk); while (count != v);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(count == 0 && !out_a && !out_b, "R1 count/outputs after reset",
              {count, out_a, out_b}, 0);
        check(!ovf_flag && !irq, "R1 flag/irq after reset", {ovf_flag, irq}, 0);
    endtask

    task automatic t_prescale();
        int divs [7] = '{1, 8, 32, 64, 128, 256, 1024};
        setup(2'd1, 1'b0, 8'd0, 8'd0, 2'd0, 2'd0);
        for (int i = 0; i < 7; i++) begin
            logic [7:0] prev;
            int n;
            @(negedge clk); clk_sel = 3'd0;
            @(negedge clk); clk_sel = 3'(i + 1);
            prev = count;
            do @(negedge clk); while (count == prev);
            prev = count;
            n = 0;
            do begin @(negedge clk); n++; end while (count == prev);
            check(n == divs[i], "R2 prescaler period", n, divs[i]);
        end
        @(negedge clk); clk_sel = 3'd0;
        begin
            logic [7:0] held;
            @(negedge clk); held = count;
            repeat (50) @(negedge clk);
            check(count == held, "R2 stopped counter holds", count, held);
        end
    endtask

    task automatic t_fast_count();
        setup(2'd1, 1'b1, 8'd9, 8'd0, 2'd0, 2'd0);
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            check(count == 8'(k % 10), "R3 single-slope TOP=A sequence", count, k % 10);
            if (k == 10) check(ovf_flag == 1'b1, "R5 flag at wrap", ovf_flag, 1);
        end
        setup(2'd1, 1'b0, 8'd9, 8'd0, 2'd0, 2'd0);
        wait_count(8'd200);
        check(count == 200, "R3 passes beyond A when TOP=0xFF", count, 200);
        wait_count(8'd255);
        @(negedge clk);
        check(count == 0, "R3 wrap after 0xFF", count, 0);
    endtask

    task automatic t_phase_count();
        setup(2'd2, 1'b1, 8'd5, 8'd0, 2'd0, 2'd0);
        for (int k = 1; k <= 23; k++) begin
            int m;
            int e;
            @(negedge clk);
            m = k % 10;
            e = (m <= 5) ? m : 10 - m;
            check(count == 8'(e), "R4 dual-slope sequence", count, e);
            if (k == 5) check(ovf_flag == 1'b0, "R5 no flag at TOP", ovf_flag, 0);
            if (k == 10) check(ovf_flag == 1'b1, "R5 flag at BOTTOM", ovf_flag, 1);
        end
    endtask

    task automatic t_ovf();
        setup(2'd1, 1'b0, 8'd0, 8'd0, 2'd0, 2'd0);
        ovf_ie = 1'b1;
        wait_count(8'd200);
        check(!ovf_flag && !irq, "R5 no flag before wrap", {ovf_flag, irq}, 0);
        wait_count(8'd0);
        check(ovf_flag && irq, "R5 flag and irq on wrap", {ovf_flag, irq}, 3);
        ovf_ie = 1'b0;
        @(negedge clk);
        check(!irq && ovf_flag, "R5 irq masked when disabled", {ovf_flag, irq}, 2);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(!ovf_flag, "R5 clear pulse", ovf_flag, 0);
    endtask

    task automatic t_fast_out();
        setup(2'd1, 1'b0, 8'd0, 8'd100, 2'd2, 2'd2);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 520; k++) begin
            @(negedge clk);
            check(out_a == (count == 0), "R6 spike with compare 0", out_a, count == 0);
            check(out_b == (count <= 100), "R6 non-inverting level", out_b, count <= 100);
        end
        write_cmp(1'b1, 8'd255);
        com_b = 2'd3;
        wait_count(8'd0);
        wait_count(8'd1);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            check(out_b == 1'b0, "R6 constant low, inverting, compare 0xFF", out_b, 0);
        end
        com_b = 2'd2;
        @(negedge clk);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            check(out_b == 1'b1, "R6 constant high, compare 0xFF", out_b, 1);
        end
    endtask

    task automatic t_phase_out();
        logic [7:0] prev;
        logic ea;
        logic eb;
        bit up;
        setup(2'd2, 1'b0, 8'd60, 8'd60, 2'd3, 2'd2);
        prev = 8'd0; ea = 1'b0; eb = 1'b0; up = 1'b1;
        for (int k = 0; k < 1100; k++) begin
            @(negedge clk);
            if (count != prev) begin
                up = (count > prev);
                if (count == 60) begin
                    eb = up ? 1'b0 : 1'b1;
                    ea = up ? 1'b1 : 1'b0;
                end
            end
            prev = count;
            check(out_b == eb, "R7 dual-slope non-inverting", out_b, eb);
            check(out_a == ea, "R7 dual-slope inverting", out_a, ea);
        end
    endtask

    task automatic t_toggle();
        logic prev;
        logic e;
        setup(2'd1, 1'b1, 8'd0, 8'd0, 2'd1, 2'd0);
        @(negedge clk);
        prev = out_a;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(out_a != prev, "R8 toggle every step at compare 0", out_a, !prev);
            prev = out_a;
        end
        setup(2'd0, 1'b0, 8'd3, 8'd0, 2'd1, 2'd0);
        e = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (count == 3) e = ~e;
            check(out_a == e, "R8 toggle on match in clear-on-compare", out_a, e);
        end
    endtask

    task automatic t_buffer();
        int mx;
        setup(2'd1, 1'b0, 8'd0, 8'd50, 2'd0, 2'd2);
        wait_count(8'd10);
        write_cmp(1'b1, 8'd200);
        wait_count(8'd100);
        check(out_b == 1'b0, "R9 single-slope keeps old compare", out_b, 0);
        wait_count(8'd100);
        check(out_b == 1'b1, "R9 single-slope new compare after wrap", out_b, 1);

        setup(2'd2, 1'b0, 8'd0, 8'd60, 2'd0, 2'd2);
        wait_count(8'd100);
        write_cmp(1'b1, 8'd30);
        wait_count(8'd45);
        check(out_b == 1'b0, "R9 dual-slope new compare after TOP", out_b, 0);
        wait_count(8'd29);
        check(out_b == 1'b1, "R9 dual-slope set at new compare", out_b, 1);

        setup(2'd0, 1'b0, 8'd100, 8'd0, 2'd0, 2'd0);
        wait_count(8'd10);
        write_cmp(1'b0, 8'd20);
        mx = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (count > mx) mx = count;
        end
        check(mx == 20, "R9 immediate compare in clear-on-compare", mx, 20);
    endtask

    task automatic t_off();
        setup(2'd1, 1'b0, 8'd5, 8'd5, 2'd0, 2'd0);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            check(!out_a && !out_b, "R10 action 0 holds low", {out_a, out_b}, 0);
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_prescale();
        t_fast_count();
        t_phase_count();
        t_ovf();
        t_fast_out();
        t_phase_out();
        t_toggle();
        t_buffer();
        t_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule